// File: doc/BRIEF.md
# Odd-Line Inversion Link Coder

This block sits in a network interface at the boundary to a point-to-point on-chip link. It reduces crosstalk energy between neighbouring wires. Every accepted payload word is `LINK_W-1` bits wide. The block compares it with the flit it last sent and counts the adjacent wire pairs that would swing in opposite directions. If such pairs form a strict majority, it flips every odd-numbered line. The result is a `LINK_W`-bit flit whose top line tells the far end whether the flip was applied.

The transmit side has a one-entry registered output stage with a valid/ready handshake. That same register is the reference for the next decision. The receive side is a purely combinational decoder. It undoes the flip using the flag line. A user sends payloads on the `in_*` side, takes flits from the `out_*` side onto the link, and feeds flits arriving from the link into `rx_flit`.

Top module: `odd_invert_link_coder`

## Requirements
- R1: A flit has `LINK_W` bits (`LINK_W` even, default 16). Bit `LINK_W-1` is the inversion flag and bits `LINK_W-2..0` carry the payload in the same positions. The candidate flit is the payload with a 0 in the flag position.
- R2: For every adjacent line pair (i, i+1), i = 0..`LINK_W-2`, the pair is favourable when both lines differ from the reference flit and the two candidate bits differ from each other, so they swing in opposite directions.
- R3: The flip is chosen when twice the number of favourable pairs exceeds `LINK_W-1`. Otherwise the candidate is sent unchanged with flag 0.
- R4: When the flip is chosen, every odd-indexed bit of the candidate is inverted, which sets the flag to 1. Even-indexed bits are sent as they are.
- R5: The reference flit resets to all zeros and changes only when a payload is accepted (`in_valid` and `in_ready` high at a clock edge). It then becomes the flit just encoded.
- R6: A payload accepted at an edge appears on `out_flit` with `out_valid` high immediately after that edge: one cycle of latency.
- R7: `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_flit` and `out_valid` hold.
- R8: `rx_payload` equals `rx_flit[LINK_W-2:0]`, with the odd-indexed bits inverted when `rx_flit[LINK_W-1]` is 1. It does this combinationally.
- R9: For a flit sent with flag 1, the number of opposite-swing pairs against the reference is strictly lower than the uninverted candidate would have had.
- R10: After reset, `out_valid` is 0, `out_flit` is all zeros and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Payload can be taken this cycle |
| in_payload | input | LINK_W-1 | Payload word |
| out_valid | output | 1 | Encoded flit present |
| out_ready | input | 1 | Link takes the flit this cycle |
| out_flit | output | LINK_W | Encoded flit, flag on top line |
| rx_flit | input | LINK_W | Flit received from the link |
| rx_payload | output | LINK_W-1 | Restored payload |

## Verification
The encoded flit and its valid bit are due one edge after acceptance. `in_ready` and the decoded payload are combinational and due in the same cycle. The bench drives inputs at the falling edge and compares the registered outputs there against a model advanced once per edge. It checks `in_ready` one time step after driving, and checks the looped-back decoder output against the payload that the model holds for the current flit. The crosstalk bound is checked on the cycle a new flit first shows, against the flit it replaced.

// File: rtl/lc_pkg.sv
package lc_pkg;
  // Two neighbouring lines swing in opposite directions between flits.
  function automatic logic opposite_swing(input logic cur_lo, input logic cur_hi,
                                          input logic prv_lo, input logic prv_hi);
    return (cur_lo ^ prv_lo) & (cur_hi ^ prv_hi) & (cur_lo ^ cur_hi);
  endfunction
endpackage

// File: rtl/lc_rst_sync.sv
module lc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lc_pair_detect.sv
module lc_pair_detect
  import lc_pkg::*;
(
  input  logic cur_lo,
  input  logic cur_hi,
  input  logic prv_lo,
  input  logic prv_hi,
  output logic hit
);
  // Flipping one line of an opposite swing leaves at most one line switching.
  always_comb hit = opposite_swing(cur_lo, cur_hi, prv_lo, prv_hi);
endmodule

// File: rtl/lc_majority.sv
module lc_majority #(
  parameter int N = 15
) (
  input  logic [N-1:0] votes,
  output logic         win
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] count;
  logic [CW:0]   doubled;

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CW'(votes[i]);
    doubled = {count, 1'b0};
    win     = doubled > (CW + 1)'(N);   // tie or fewer: no flip
  end
endmodule

// File: rtl/lc_odd_decoder.sv
module lc_odd_decoder #(
  parameter int LINK_W = 16
) (
  input  logic [LINK_W-1:0] flit,
  output logic [LINK_W-2:0] payload
);
  localparam int PW = LINK_W - 1;

  logic [PW-1:0] odd_mask;

  for (genvar i = 0; i < PW; i++) begin : g_mask
    assign odd_mask[i] = (i % 2) == 1;
  end

  assign payload = flit[PW-1:0] ^ (flit[LINK_W-1] ? odd_mask : '0);
endmodule

// File: rtl/odd_invert_link_coder.sv
module odd_invert_link_coder #(
  parameter int LINK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LINK_W-2:0] in_payload,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINK_W-1:0] out_flit,
  input  logic [LINK_W-1:0] rx_flit,
  output logic [LINK_W-2:0] rx_payload
);
  localparam int NPAIRS = LINK_W - 1;

  logic              rst_sync_n;
  logic [LINK_W-1:0] cand;
  logic [LINK_W-1:0] odd_mask;
  logic [LINK_W-1:0] enc;
  logic [NPAIRS-1:0] pair_hit;
  logic              do_flip;
  logic              accept;
  logic [LINK_W-1:0] flit_q, flit_d;
  logic              valid_q, valid_d;

  lc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cand = {1'b0, in_payload};

  for (genvar i = 0; i < LINK_W; i++) begin : g_mask
    assign odd_mask[i] = (i % 2) == 1;
  end

  // Reference flit is the output register: last accepted encoding.
  for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
    lc_pair_detect u_pair (
      .cur_lo (cand[i]),
      .cur_hi (cand[i+1]),
      .prv_lo (flit_q[i]),
      .prv_hi (flit_q[i+1]),
      .hit    (pair_hit[i])
    );
  end

  lc_majority #(.N(NPAIRS)) u_vote (
    .votes (pair_hit),
    .win   (do_flip)
  );

  assign enc      = cand ^ (do_flip ? odd_mask : '0);
  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    flit_d  = flit_q;
    valid_d = valid_q;
    if (accept) begin
      flit_d  = enc;
      valid_d = 1'b1;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flit_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      flit_q  <= flit_d;
      valid_q <= valid_d;
    end
  end

  assign out_flit  = flit_q;
  assign out_valid = valid_q;

  lc_odd_decoder #(.LINK_W(LINK_W)) u_dec (
    .flit    (rx_flit),
    .payload (rx_payload)
  );

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit))); // R7
  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready) |=> out_valid); // R6
  AST_REF_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(in_valid && in_ready) |=> $stable(out_flit)); // R5
  AST_FLAG_FOLLOWS_VOTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready && do_flip) |=> out_flit[LINK_W-1]); // R4
  AST_NO_FLAG_WITHOUT_VOTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready && !do_flip) |=> !out_flit[LINK_W-1]); // R3
endmodule

// File: tb/tb_odd_invert_link_coder.sv
module tb_odd_invert_link_coder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [W-2:0] in_payload, rx_payload;
  logic [W-1:0] out_flit, rx_flit;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rx_flit = out_flit;   // link loopback into decoder

  odd_invert_link_coder #(.LINK_W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
    .rx_flit(rx_flit), .rx_payload(rx_payload)
  );

  // model state
  logic [W-1:0] m_flit, m_prev, m_cand;
  logic [W-2:0] m_pay;
  bit           m_valid, m_new;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2: opposite-swing pairs between two flits
  function automatic int swings(input logic [W-1:0] c, input logic [W-1:0] p);
    int n = 0;
    for (int i = 0; i < W-1; i++)
      if (c[i] != p[i] && c[i+1] != p[i+1] && c[i] != c[i+1]) n++;
    return n;
  endfunction

  // R1/R3/R4 reference encoding
  function automatic logic [W-1:0] ref_enc(input logic [W-2:0] pay, input logic [W-1:0] prv);
    logic [W-1:0] c = {1'b0, pay};
    if (2 * swings(c, prv) > W-1)
      for (int i = 1; i < W; i += 2) c[i] = ~c[i];
    return c;
  endfunction

  task automatic cycle(input bit v, input logic [W-2:0] pay, input bit ordy);
    bit exp_rdy;
    @(negedge clk);
    chk(out_valid == m_valid, "R6 out_valid", W'(out_valid), W'(m_valid));
    chk(out_flit == m_flit, "R3/R4/R5 out_flit", out_flit, m_flit);
    if (m_valid) chk(rx_payload == m_pay, "R8 decode", W'(rx_payload), W'(m_pay));
    if (m_new) begin
      if (out_flit[W-1])
        chk(swings(out_flit, m_prev) < swings(m_cand, m_prev), "R9 swing bound",
            W'(swings(out_flit, m_prev)), W'(swings(m_cand, m_prev)));
      else
        chk(2 * swings(m_cand, m_prev) <= W-1, "R3 no-flip vote",
            W'(swings(m_cand, m_prev)), W'((W-1)/2));
    end
    in_valid = v; in_payload = pay; out_ready = ordy;
    #1;
    exp_rdy = !m_valid || ordy;
    chk(in_ready == exp_rdy, "R7 in_ready", W'(in_ready), W'(exp_rdy));
    m_new = 0;
    if (v && exp_rdy) begin
      m_prev  = m_flit;
      m_cand  = {1'b0, pay};
      m_flit  = ref_enc(pay, m_flit);
      m_valid = 1;
      m_pay   = pay;
      m_new   = 1;
    end else if (ordy) begin
      m_valid = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-2:0] cnt;
    rst_n = 0; in_valid = 0; in_payload = '0; out_ready = 0;
    m_flit = '0; m_prev = '0; m_cand = '0; m_pay = '0; m_valid = 0; m_new = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 1'b0, "R10 out_valid", W'(out_valid), '0);
    chk(out_flit == '0, "R10 out_flit", out_flit, '0);
    chk(in_ready == 1'b1, "R10 in_ready", W'(in_ready), W'(1));

    // directed: alternating then complement forces a flip (expect 16'h8000)
    cycle(1, 15'h5555, 1);
    cycle(1, 15'h2AAA, 1);
    cycle(0, '0, 1);
    chk(m_flit == 16'h8000, "R4 directed flip", m_flit, 16'h8000);

    // stall: flit held, new payload refused, reference unchanged (R5, R7)
    cycle(1, 15'h1234, 0);
    for (int k = 0; k < 4; k++) cycle(1, 15'h7F0F ^ 15'(k), 0);
    cycle(0, '0, 1);
    cycle(1, 15'h0F0F, 1);

    // random streams with random back-pressure
    for (int k = 0; k < 400; k++)
      cycle($urandom_range(0, 3) != 0, 15'($urandom), $urandom_range(0, 3) != 0);

    // correlated: counting, toggling and complementing patterns
    cnt = '0;
    for (int k = 0; k < 400; k++) begin
      case (k % 4)
        0: cnt = cnt + 1;
        1: cnt = ~cnt;
        2: cnt = cnt ^ 15'h2AAA;
        default: cnt = cnt ^ 15'h5555;
      endcase
      cycle(1, cnt, $urandom_range(0, 4) != 0);
    end
    cycle(0, '0, 1);
    cycle(0, '0, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule